// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for two hardware threads that share one core. It holds a pool of return-target entries, 32 by default. While both threads are active (both in C0), the pool is split into two private circular stacks of half the size: thread 0 owns the lower half and thread 1 the upper half. When either thread leaves C0, the core runs single-threaded. The remaining active thread then treats the whole pool as one circular stack.

A mode change never touches the stored targets. Only the stack pointers are remapped. The active thread keeps its physical index when the pool is merged. When the pool is split again, each pointer is folded back into its own thread's half. One result is that a return predicted soon after a merge can pick up a target that the now-idle thread pushed. A build parameter can instead invalidate every entry on each mode switch. That lets a design trade the retained-contents behaviour for a scrubbed pool.

Each thread issues call pushes (with the return target) and return pops. Each cycle the block presents the current top-of-stack target and a valid flag per thread.

Top module: `rap_smt_stack`

## Requirements
- R1: While reset is asserted and right after its release, both `pred_vld` bits are 0 and the block is in dual-thread mode.
- R2: In dual-thread mode, thread 0 uses entries 0–15 and thread 1 uses entries 16–31, each as a separate LIFO. A push makes its target the thread's prediction on the next cycle, and a pop exposes the previous push.
- R3: In dual-thread mode, a thread's 17th push without pops overwrites that thread's oldest entry. After 16 pops its prediction is invalid.
- R4: A pop while the thread's top entry is invalid changes nothing, and `pred_vld` for that thread stays 0.
- R5: A push and a pop from the same thread in the same cycle replace the top entry with the new target and leave the depth unchanged.
- R6: The block is in dual-thread mode after a cycle with `c0_active == 2'b11`, and in single-thread mode otherwise. In single-thread mode the active thread is the one whose `c0_active` bit is 1. The idle thread's `pred_vld` is 0, and its pushes and pops are ignored.
- R7: In a cycle that changes the mode (or the active thread), pushes and pops are ignored and entry contents are kept. On merging, the active thread keeps its physical index. On splitting, each pointer's top index bit is forced to its thread number.
- R8: In single-thread mode the active thread's pointer wraps across all 32 entries, so pops can expose targets that the other thread pushed.
- R9: With `SCRUB_ON_SWITCH` set, every mode or active-thread switch invalidates all entries, so both predictions are invalid after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_active | input | 2 | Per-thread C0 status, 1 = active |
| push | input | 2 | Per-thread call push |
| push_tgt | input | 2 x TW | Per-thread return target to push |
| pop | input | 2 | Per-thread return pop |
| pred_tgt | output | 2 x TW | Per-thread predicted return target |
| pred_vld | output | 2 | Per-thread prediction valid |

## Verification
The property checks on pushes and empty pops assume a cycle in which the block is already in dual-thread mode and both C0 inputs stay high, so that no remap or scrub occurs at the same edge. Mode properties assume the C0 inputs are sampled at the clock edge like every other input. The stimulus changes all inputs only on the falling edge. It keeps both threads in C0 for most random cycles. It drops one or both C0 bits in short bursts, so that switches, idle-thread pushes and single-mode wrap all occur while the dual-mode windows stay long enough for the push checks to fire.

// File: rtl/rap_pkg.sv
`timescale 1ns/1ps
package rap_pkg;
  localparam int NTHR = 2;

  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_SINGLE = 1'b1
  } rap_mode_e;
endpackage

// File: rtl/rap_mode_ctrl.sv
`timescale 1ns/1ps
module rap_mode_ctrl
  import rap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] c0_i,
  output rap_mode_e mode_q_o,
  output rap_mode_e mode_d_o,
  output logic      act_q_o,
  output logic      switch_o
);
  rap_mode_e mode_q, mode_d;
  logic      act_q, act_d;

  always_comb begin
    mode_d = (&c0_i) ? MODE_DUAL : MODE_SINGLE;
    act_d  = act_q;
    if (c0_i == 2'b01) act_d = 1'b0;
    else if (c0_i == 2'b10) act_d = 1'b1;
    switch_o = (mode_d != mode_q) ||
               ((mode_q == MODE_SINGLE) && (mode_d == MODE_SINGLE) && (act_d != act_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_DUAL;
      act_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      act_q  <= act_d;
    end
  end

  assign mode_q_o = mode_q;
  assign mode_d_o = mode_d;
  assign act_q_o  = act_q;
endmodule

// File: rtl/rap_ptr_unit.sv
`timescale 1ns/1ps
module rap_ptr_unit
  import rap_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int THR   = 0,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rap_mode_e     mode_q,
  input  rap_mode_e     mode_d,
  input  logic          switch_i,
  input  logic          en_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          top_vld_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_idx_o,
  output logic          clr_en_o,
  output logic [AW-1:0] clr_idx_o
);
  localparam logic          THR_BIT = (THR != 0);
  localparam logic [AW-1:0] RST_PTR = {THR_BIT, {(AW-1){1'b0}}};

  logic [AW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic          ptr_upd;

  always_comb begin
    if (mode_q == MODE_SINGLE) begin
      ptr_inc = ptr_q + 1'b1;
      ptr_dec = ptr_q - 1'b1;
    end else begin
      ptr_inc = {ptr_q[AW-1], ptr_q[AW-2:0] + 1'b1};
      ptr_dec = {ptr_q[AW-1], ptr_q[AW-2:0] - 1'b1};
    end

    ptr_d     = ptr_q;
    wr_en_o   = 1'b0;
    wr_idx_o  = ptr_q;
    clr_en_o  = 1'b0;
    clr_idx_o = ptr_q;
    if (switch_i) begin
      if (mode_d == MODE_DUAL) ptr_d[AW-1] = THR_BIT;
    end else if (en_i) begin
      if (push_i && pop_i) begin
        wr_en_o = 1'b1;
      end else if (push_i) begin
        wr_en_o  = 1'b1;
        wr_idx_o = ptr_inc;
        ptr_d    = ptr_inc;
      end else if (pop_i && top_vld_i) begin
        clr_en_o = 1'b1;
        ptr_d    = ptr_dec;
      end
    end
    ptr_upd = (ptr_d != ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= RST_PTR;
    else if (ptr_upd) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rap_store.sv
`timescale 1ns/1ps
module rap_store #(
  parameter  int DEPTH = 32,
  parameter  int TW    = 32,
  parameter  int NP    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          wr_en,
  input  logic [NP-1:0][AW-1:0]  wr_idx,
  input  logic [NP-1:0][TW-1:0]  wr_tgt,
  input  logic [NP-1:0]          clr_en,
  input  logic [NP-1:0][AW-1:0]  clr_idx,
  input  logic                   clr_all,
  input  logic [NP-1:0][AW-1:0]  rd_idx,
  output logic [NP-1:0][TW-1:0]  rd_tgt,
  output logic [NP-1:0]          rd_vld
);
  logic [TW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    for (int e = 0; e < DEPTH; e++) begin
      for (int p = 0; p < NP; p++) begin
        if (clr_en[p] && (clr_idx[p] == AW'(e))) vld_d[e] = 1'b0;
      end
      for (int p = 0; p < NP; p++) begin
        if (wr_en[p] && (wr_idx[p] == AW'(e))) vld_d[e] = 1'b1;
      end
    end
    if (clr_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      for (int p = 0; p < NP; p++) begin
        if (wr_en[p] && (wr_idx[p] == AW'(e))) mem_q[e] <= wr_tgt[p];
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_tgt[p] = mem_q[rd_idx[p]];
    assign rd_vld[p] = vld_q[rd_idx[p]];
  end
endmodule

// File: rtl/rap_smt_stack.sv
`timescale 1ns/1ps
module rap_smt_stack
  import rap_pkg::*;
#(
  parameter  int DEPTH           = 32,
  parameter  int TW              = 32,
  parameter  bit SCRUB_ON_SWITCH = 1'b0,
  localparam int AW              = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHR-1:0]          c0_active,
  input  logic [NTHR-1:0]          push,
  input  logic [NTHR-1:0][TW-1:0]  push_tgt,
  input  logic [NTHR-1:0]          pop,
  output logic [NTHR-1:0][TW-1:0]  pred_tgt,
  output logic [NTHR-1:0]          pred_vld
);
  rap_mode_e mode_q, mode_d;
  logic      act_q, switch_w, single_q;

  logic [NTHR-1:0][AW-1:0] ptr, wr_idx, clr_idx;
  logic [NTHR-1:0]         wr_en, clr_en, en, rd_vld;

  rap_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .c0_i     (c0_active),
    .mode_q_o (mode_q),
    .mode_d_o (mode_d),
    .act_q_o  (act_q),
    .switch_o (switch_w)
  );

  assign single_q = (mode_q == MODE_SINGLE);

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam logic GB = (g != 0);
    assign en[g]       = !switch_w && c0_active[g] && (!single_q || (act_q == GB));
    assign pred_vld[g] = rd_vld[g] && (!single_q || (act_q == GB));

    rap_ptr_unit #(.DEPTH(DEPTH), .THR(g)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_q    (mode_q),
      .mode_d    (mode_d),
      .switch_i  (switch_w),
      .en_i      (en[g]),
      .push_i    (push[g]),
      .pop_i     (pop[g]),
      .top_vld_i (rd_vld[g]),
      .ptr_o     (ptr[g]),
      .wr_en_o   (wr_en[g]),
      .wr_idx_o  (wr_idx[g]),
      .clr_en_o  (clr_en[g]),
      .clr_idx_o (clr_idx[g])
    );
  end

  rap_store #(.DEPTH(DEPTH), .TW(TW), .NP(NTHR)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tgt  (push_tgt),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .clr_all (SCRUB_ON_SWITCH && switch_w),
    .rd_idx  (ptr),
    .rd_tgt  (pred_tgt),
    .rd_vld  (rd_vld)
  );
endmodule

// File: rtl/rap_smt_stack_chk.sv
`timescale 1ns/1ps
module rap_smt_stack_chk #(
  parameter int TW    = 32,
  parameter bit SCRUB = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          c0_active,
  input logic [1:0]          push,
  input logic [1:0]          pop,
  input logic [1:0][TW-1:0]  push_tgt,
  input logic [1:0][TW-1:0]  pred_tgt,
  input logic [1:0]          pred_vld,
  input logic                single_q,
  input logic                act_q
);
  assert_dual_when_both_c0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_active == 2'b11) |=> !single_q);

  assert_single_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_active != 2'b11) |=> single_q);

  assert_idle_thread_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> !pred_vld[!act_q]);

  assert_single_one_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> $onehot0(pred_vld));

  for (genvar t = 0; t < 2; t++) begin : g_t
    assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && (c0_active == 2'b11) && push[t])
        |=> (pred_vld[t] && (pred_tgt[t] == $past(push_tgt[t]))));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_q && (c0_active == 2'b11) && pop[t] && !push[t] && !pred_vld[t])
        |=> !pred_vld[t]);
  end

  if (SCRUB) begin : g_scrub
    assert_scrub_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (single_q != $past(single_q)) |-> (pred_vld == 2'b00));
  end
endmodule

bind rap_smt_stack rap_smt_stack_chk #(.TW(TW), .SCRUB(SCRUB_ON_SWITCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .c0_active (c0_active),
  .push      (push),
  .pop       (pop),
  .push_tgt  (push_tgt),
  .pred_tgt  (pred_tgt),
  .pred_vld  (pred_vld),
  .single_q  (single_q),
  .act_q     (act_q)
);

// File: tb/rap_smt_stack_bench.sv
`timescale 1ns/1ps
module rap_smt_stack_bench;
  localparam int TW = 32;
  localparam int DEPTH = 32;
  localparam int HALF = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [1:0] c0, push, pop;
  logic [1:0][TW-1:0] tgt;
  logic [1:0][TW-1:0] pt_a, pt_b;
  logic [1:0] pv_a, pv_b;

  int n_tests = 0;
  int n_fail = 0;

  rap_smt_stack #(.DEPTH(DEPTH), .TW(TW), .SCRUB_ON_SWITCH(1'b0)) u_rap_smt_stack (
    .clk(clk), .rst_n(rst_n), .c0_active(c0), .push(push), .push_tgt(tgt),
    .pop(pop), .pred_tgt(pt_a), .pred_vld(pv_a));

  rap_smt_stack #(.DEPTH(DEPTH), .TW(TW), .SCRUB_ON_SWITCH(1'b1)) u_rap_smt_stack_scrub (
    .clk(clk), .rst_n(rst_n), .c0_active(c0), .push(push), .push_tgt(tgt),
    .pop(pop), .pred_tgt(pt_b), .pred_vld(pv_b));

  // Reference model, index 0 = retaining build, 1 = scrubbing build
  bit          m_single [2];
  int          m_act    [2];
  int          m_ptr    [2][2];
  logic [31:0] m_mem    [2][DEPTH];
  bit          m_vld    [2][DEPTH];

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_single[m] = 0; m_act[m] = 0;
      m_ptr[m][0] = 0; m_ptr[m][1] = HALF;
      for (int e = 0; e < DEPTH; e++) m_vld[m][e] = 0;
    end
  endtask

  function automatic int step_ptr(bit single, int p, int d);
    if (single) return (p + d + DEPTH) % DEPTH;
    return (p / HALF) * HALF + ((p % HALF) + d + HALF) % HALF;
  endfunction

  task automatic model_step(int m, bit scrub);
    bit nsingle, sw;
    int nact;
    nsingle = !(c0[0] && c0[1]);
    nact = (c0 == 2'b01) ? 0 : (c0 == 2'b10) ? 1 : m_act[m];
    sw = (nsingle != m_single[m]) || (m_single[m] && nsingle && nact != m_act[m]);
    if (sw) begin
      if (scrub) for (int e = 0; e < DEPTH; e++) m_vld[m][e] = 0;
      if (!nsingle) for (int t = 0; t < 2; t++) m_ptr[m][t] = (m_ptr[m][t] % HALF) + HALF * t;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (c0[t] && (!m_single[m] || m_act[m] == t)) begin
          int p = m_ptr[m][t];
          if (push[t] && pop[t]) begin
            m_mem[m][p] = tgt[t]; m_vld[m][p] = 1;
          end else if (push[t]) begin
            p = step_ptr(m_single[m], p, 1);
            m_mem[m][p] = tgt[t]; m_vld[m][p] = 1; m_ptr[m][t] = p;
          end else if (pop[t] && m_vld[m][p]) begin
            m_vld[m][p] = 0; m_ptr[m][t] = step_ptr(m_single[m], p, -1);
          end
        end
      end
    end
    m_single[m] = nsingle;
    m_act[m] = nact;
  endtask

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare_all(string rq);
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 2; t++) begin
        bit ev = m_vld[m][m_ptr[m][t]] && (!m_single[m] || m_act[m] == t);
        logic av = (m == 0) ? pv_a[t] : pv_b[t];
        logic [31:0] at = (m == 0) ? pt_a[t] : pt_b[t];
        check(rq, {31'b0, av}, {31'b0, ev});
        if (ev) check(rq, at, m_mem[m][m_ptr[m][t]]);
      end
    end
  endtask

  task automatic step(logic [1:0] c0v, logic [1:0] pushv, logic [1:0] popv,
                      logic [31:0] t0, logic [31:0] t1, string rq);
    @(negedge clk);
    c0 = c0v; push = pushv; pop = popv; tgt[0] = t0; tgt[1] = t1;
    @(posedge clk);
    model_step(0, 1'b0);
    model_step(1, 1'b1);
    #1;
    compare_all(rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; c0 = 2'b11; push = '0; pop = '0; tgt = '0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1", {30'b0, pv_a}, 32'd0);
    check("R1", {30'b0, pv_b}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    do_reset();
    step(2'b11, 2'b00, 2'b00, 0, 0, "R1");
    check("R1", {30'b0, pv_a}, 32'd0);

    // R2: private LIFOs in dual mode
    step(2'b11, 2'b11, 2'b00, 32'h10, 32'h20, "R2");
    step(2'b11, 2'b01, 2'b00, 32'h11, 0, "R2");
    check("R2", pt_a[0], 32'h11);
    check("R2", pt_a[1], 32'h20);
    step(2'b11, 2'b00, 2'b01, 0, 0, "R2");
    check("R2", pt_a[0], 32'h10);
    step(2'b11, 2'b00, 2'b01, 0, 0, "R2");
    // R4: pop on empty keeps valid low
    step(2'b11, 2'b00, 2'b01, 0, 0, "R4");
    check("R4", {31'b0, pv_a[0]}, 32'd0);

    // R3: overflow overwrites oldest
    do_reset();
    for (int i = 0; i < 17; i++) step(2'b11, 2'b01, 2'b00, 32'h100 + i, 0, "R3");
    check("R3", pt_a[0], 32'h110);
    for (int i = 0; i < 15; i++) step(2'b11, 2'b00, 2'b01, 0, 0, "R3");
    check("R3", pt_a[0], 32'h101);
    step(2'b11, 2'b00, 2'b01, 0, 0, "R3");
    check("R3", {31'b0, pv_a[0]}, 32'd0);
    step(2'b11, 2'b00, 2'b01, 0, 0, "R4");
    check("R4", {31'b0, pv_a[0]}, 32'd0);

    // R5: push and pop together replace the top
    step(2'b11, 2'b10, 2'b00, 0, 32'h55, "R5");
    step(2'b11, 2'b10, 2'b10, 0, 32'h66, "R5");
    check("R5", pt_a[1], 32'h66);
    step(2'b11, 2'b00, 2'b10, 0, 0, "R5");
    check("R5", {31'b0, pv_a[1]}, 32'd0);

    // R6/R7/R8/R9: merge exposes the sibling's targets
    do_reset();
    for (int i = 0; i < 16; i++) step(2'b11, 2'b11, 2'b00, 32'hA00 + i, 32'hB00 + i, "R2");
    step(2'b01, 2'b11, 2'b00, 32'hDEAD, 32'hBEEF, "R7");
    check("R7", pt_a[0], 32'hA0F);
    check("R6", {31'b0, pv_a[1]}, 32'd0);
    check("R9", {30'b0, pv_b}, 32'd0);
    step(2'b01, 2'b10, 2'b01, 0, 32'hBAD, "R8");
    check("R8", pt_a[0], 32'hB0E);
    check("R8", {31'b0, pv_a[0]}, 32'd1);
    step(2'b11, 2'b11, 2'b11, 32'h1, 32'h2, "R7");
    check("R7", pt_a[0], 32'hA0E);
    check("R7", pt_a[1], 32'hB0F);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] c0r = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      step(c0r, 2'($urandom), 2'($urandom), $urandom, $urandom,
           m_single[0] ? "R8" : "R2");
    end
    finish_run();
  end
endmodule